// File: doc/BRIEF.md
# Transmit Descriptor Chain Engine

This block walks a linked list of transmit descriptors kept in system memory and turns each one into a buffer request for a downstream byte mover. Each descriptor is four 32-bit words at a 16-byte-aligned address:

| Word | Contents |
|------|----------|
| 0 | ownership and status |
| 1 | control bits and buffer length |
| 2 | buffer address |
| 3 | next-descriptor address, used in chained mode |

Software builds the descriptors and sets the ownership bit on each one. It then writes the poll-demand input to start the engine. The engine reads descriptors one at a time through a single request/response memory port. For each owned descriptor it issues one buffer request to the mover. When the mover reports completion, the engine writes word 0 back with ownership cleared and the transfer status filled in. It then follows the chain. When it reads a descriptor that software still owns, it parks, and it waits for the next poll demand before trying that same descriptor again.

Frames may span several descriptors. The first-segment and last-segment marks are forwarded with each buffer request, so the mover can frame the data. A descriptor with interrupt-on-completion set produces a one-cycle completion pulse once its status has been written back.

Top module: `txdesc_chain_engine`

## Requirements
- R1: After reset, `suspended` is 1, `mem_req`, `buf_valid` and `tx_done` are 0, and the descriptor pointer equals `chain_head`.
- R2: A poll write with `poll_wdata[0]`=1 starts a fetch of four words at byte addresses ptr, ptr+4, ptr+8, ptr+12. A poll write with bit 0 = 0 has no effect: no memory read occurs and `suspended` stays 1.
- R3: A fetched descriptor with word0[31]=0 (host owned) produces no buffer request and no write. The engine returns to `suspended`, and the next accepted poll refetches the same address.
- R4: For an owned descriptor with word1[10:0] non-zero, the engine raises `buf_valid` with these fields, held stable until `buf_ready`:

  | Output | Source |
  |--------|--------|
  | `buf_addr` | word2 |
  | `buf_len` | word1[10:0] |
  | `buf_last` | word1[30] |
  | `buf_first` | word1[29] |
  | `buf_csum` | word1[28:27] |
  | `buf_nocrc` | word1[26] |

  The field word1[21:11] is ignored.
- R5: After `xfer_done`, the engine writes word 0 at the descriptor address. Bit 31 is 0. The other bits are set as follows, and all remaining bits are 0:

  | Bit(s) | Value |
  |--------|-------|
  | 15 | underflow OR jabber OR flushed |
  | 14 | jabber |
  | 13 | flushed |
  | 6:3 | collision count |
  | 1 | underflow |

- R6: If word1[24]=1 (chained), the next descriptor address is word3.
- R7: If word1[24]=0 (ring), the next address is the current address + 16, or `chain_head` when word1[25]=1 (end of ring).
- R8: An owned descriptor with word1[10:0]=0 issues no buffer request. Its word 0 is written back as 0, and the walk continues.
- R9: `tx_done` pulses for exactly one cycle after the write-back of a descriptor with word1[31]=1. It stays 0 for all other descriptors.
- R10: The memory port has at most one access in flight. `mem_req` is a single-cycle pulse, and the next request waits for `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| chain_head | input | AW | first descriptor address, also the ring wrap target |
| poll_we | input | 1 | poll-demand register write strobe |
| poll_wdata | input | 32 | poll-demand write data; bit 0 requests a fetch |
| mem_req | output | 1 | memory access request pulse |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | byte address of the access |
| mem_wdata | output | 32 | write data |
| mem_rvalid | input | 1 | read data valid or write acknowledge |
| mem_rdata | input | 32 | read data |
| buf_valid | output | 1 | buffer request valid |
| buf_ready | input | 1 | mover accepts the request |
| buf_addr | output | AW | buffer start address |
| buf_len | output | 11 | buffer length in bytes |
| buf_first | output | 1 | first segment of a frame |
| buf_last | output | 1 | last segment of a frame |
| buf_csum | output | 2 | checksum insertion mode |
| buf_nocrc | output | 1 | suppress CRC append |
| xfer_done | input | 1 | mover finished the current buffer |
| xfer_underflow | input | 1 | mover status: underflow |
| xfer_jabber | input | 1 | mover status: jabber timeout |
| xfer_flushed | input | 1 | mover status: frame flushed |
| xfer_coll | input | 4 | mover status: collision count |
| tx_done | output | 1 | completion pulse |
| suspended | output | 1 | engine parked, waiting for a poll demand |

## Verification
The hardest situation to reach is the suspend-and-resume path. The engine must park on a host-owned descriptor, and a later poll must restart at exactly that address rather than at the head or the next stride. The bench sets this up by leaving an unowned terminator behind each chain. It confirms the walk parks there, then hands the terminator over by setting its ownership and writing the poll again. The order of fetch addresses seen on the memory port shows where each walk started. Back-pressure on the buffer handshake is also forced: the mover stub withholds ready for several cycles on one request.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

  // descriptor geometry
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * 4;

  // word 0 (ownership / write-back status)
  localparam int OWN_B   = 31;
  localparam int ES_B    = 15;
  localparam int JAB_B   = 14;
  localparam int FLUSH_B = 13;
  localparam int COLL_LO = 3;
  localparam int COLL_W  = 4;
  localparam int UFL_B   = 1;

  // word 1 (control / length)
  localparam int IRQ_B   = 31;
  localparam int LAST_B  = 30;
  localparam int FIRST_B = 29;
  localparam int CSUM_LO = 27;
  localparam int NOCRC_B = 26;
  localparam int WRAP_B  = 25;
  localparam int LINK_B  = 24;
  localparam int SIZE_LO = 0;
  localparam int SIZE_W  = 11;

  typedef enum logic [2:0] {
    S_PARK,
    S_FETCH_GO,
    S_FETCH,
    S_DECIDE,
    S_XFER,
    S_WAIT,
    S_WB_GO,
    S_WB
  } eng_state_t;

  typedef struct packed {
    logic              underflow;
    logic              jabber;
    logic              flushed;
    logic [COLL_W-1:0] coll;
  } xfer_stat_t;

endpackage

// File: rtl/txdesc_poll_latch.sv
module txdesc_poll_latch (
  input  logic clk,
  input  logic rst,
  input  logic poll_we,
  input  logic poll_bit,
  input  logic take,
  output logic pending
);

  // a new demand wins over a same-cycle take so no demand is lost
  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= (pending & ~take) | (poll_we & poll_bit);
  end

endmodule

// File: rtl/txdesc_word_loader.sv
module txdesc_word_loader #(
  parameter int AW = 32,
  parameter int NW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_start,
  input  logic                 wr_start,
  input  logic [AW-1:0]        base,
  input  logic [31:0]          wdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_rvalid,
  input  logic [31:0]          mem_rdata,
  output logic                 done,
  output logic [NW-1:0][31:0]  words
);

  localparam int IW = (NW > 1) ? $clog2(NW) : 1;

  logic          waiting;
  logic [IW-1:0] idx;
  logic          beat;

  assign beat = waiting && mem_rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      waiting   <= 1'b0;
      idx       <= '0;
      done      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      if (rd_start) begin
        mem_req  <= 1'b1;
        mem_we   <= 1'b0;
        mem_addr <= base;
        idx      <= '0;
        waiting  <= 1'b1;
      end else if (wr_start) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= base;
        mem_wdata <= wdata;
        idx       <= '0;
        waiting   <= 1'b1;
      end else if (beat) begin
        if (!mem_we && idx != IW'(NW-1)) begin
          idx      <= idx + 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= mem_addr + AW'(4);
        end else begin
          waiting <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [31:0] w_q;
    always_ff @(posedge clk) begin
      if (rst)
        w_q <= '0;
      else if (beat && !mem_we && idx == IW'(g))
        w_q <= mem_rdata;
    end
    assign words[g] = w_q;
  end

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R10
  AST_REQ_TRACKED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> waiting); // R10

endmodule

// File: rtl/txdesc_status_pack.sv
module txdesc_status_pack
  import txdesc_pkg::*;
(
  input  xfer_stat_t  st,
  output logic [31:0] word
);

  always_comb begin
    word = '0;
    word[ES_B]                  = st.underflow | st.jabber | st.flushed;
    word[JAB_B]                 = st.jabber;
    word[FLUSH_B]               = st.flushed;
    word[COLL_LO +: COLL_W]     = st.coll;
    word[UFL_B]                 = st.underflow;
  end

endmodule

// File: rtl/txdesc_chain_engine.sv
module txdesc_chain_engine
  import txdesc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     chain_head,
  input  logic              poll_we,
  input  logic [31:0]       poll_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              buf_valid,
  input  logic              buf_ready,
  output logic [AW-1:0]     buf_addr,
  output logic [SIZE_W-1:0] buf_len,
  output logic              buf_first,
  output logic              buf_last,
  output logic [1:0]        buf_csum,
  output logic              buf_nocrc,
  input  logic              xfer_done,
  input  logic              xfer_underflow,
  input  logic              xfer_jabber,
  input  logic              xfer_flushed,
  input  logic [COLL_W-1:0] xfer_coll,
  output logic              tx_done,
  output logic              suspended
);

  eng_state_t                     state;
  logic [AW-1:0]                  cur_ptr;
  logic [AW-1:0]                  head_q;
  logic [31:0]                    wb_word;
  logic                           pending;
  logic                           take;
  logic                           ld_done;
  logic [DESC_WORDS-1:0][31:0]    words;
  logic [31:0]                    stat_word;
  xfer_stat_t                     stat_in;
  logic [31:0]                    ctl;
  logic [AW-1:0]                  next_ptr;

  assign take = (state == S_PARK) && pending;
  assign ctl  = words[1];

  assign stat_in = '{underflow: xfer_underflow, jabber: xfer_jabber,
                     flushed: xfer_flushed, coll: xfer_coll};

  always_comb begin
    if (ctl[LINK_B])      next_ptr = words[3][AW-1:0];
    else if (ctl[WRAP_B]) next_ptr = head_q;
    else                  next_ptr = cur_ptr + AW'(DESC_BYTES);
  end

  txdesc_poll_latch u_poll (
    .clk      (clk),
    .rst      (rst),
    .poll_we  (poll_we),
    .poll_bit (poll_wdata[0]),
    .take     (take),
    .pending  (pending)
  );

  txdesc_word_loader #(.AW(AW), .NW(DESC_WORDS)) u_load (
    .clk        (clk),
    .rst        (rst),
    .rd_start   (state == S_FETCH_GO),
    .wr_start   (state == S_WB_GO),
    .base       (cur_ptr),
    .wdata      (wb_word),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (ld_done),
    .words      (words)
  );

  txdesc_status_pack u_pack (
    .st   (stat_in),
    .word (stat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_PARK;
      cur_ptr   <= chain_head;
      head_q    <= chain_head;
      wb_word   <= '0;
      buf_valid <= 1'b0;
      buf_addr  <= '0;
      buf_len   <= '0;
      buf_first <= 1'b0;
      buf_last  <= 1'b0;
      buf_csum  <= '0;
      buf_nocrc <= 1'b0;
      tx_done   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      unique case (state)
        S_PARK:     if (pending) state <= S_FETCH_GO;
        S_FETCH_GO: state <= S_FETCH;
        S_FETCH:    if (ld_done) state <= S_DECIDE;
        S_DECIDE: begin
          if (!words[0][OWN_B]) begin
            state <= S_PARK;
          end else if (ctl[SIZE_LO +: SIZE_W] == '0) begin
            wb_word <= '0;
            state   <= S_WB_GO;
          end else begin
            buf_valid <= 1'b1;
            buf_addr  <= words[2][AW-1:0];
            buf_len   <= ctl[SIZE_LO +: SIZE_W];
            buf_first <= ctl[FIRST_B];
            buf_last  <= ctl[LAST_B];
            buf_csum  <= ctl[CSUM_LO +: 2];
            buf_nocrc <= ctl[NOCRC_B];
            state     <= S_XFER;
          end
        end
        S_XFER: if (buf_ready) begin
          buf_valid <= 1'b0;
          state     <= S_WAIT;
        end
        S_WAIT: if (xfer_done) begin
          wb_word <= stat_word;
          state   <= S_WB_GO;
        end
        S_WB_GO: state <= S_WB;
        S_WB: if (ld_done) begin
          tx_done <= ctl[IRQ_B];
          cur_ptr <= next_ptr;
          state   <= S_FETCH_GO;
        end
        default: state <= S_PARK;
      endcase
    end
  end

  assign suspended = (state == S_PARK);

  AST_PARK_QUIET: assert property (@(posedge clk) disable iff (rst)
    suspended |-> (!buf_valid && !mem_req)); // R3
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len))); // R4
  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[OWN_B]); // R5
  AST_NO_EMPTY_BUF: assert property (@(posedge clk) disable iff (rst)
    buf_valid |-> (buf_len != '0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done); // R9

endmodule

// File: tb/txdesc_chain_engine_test.sv
`timescale 1ns/1ps
module txdesc_chain_engine_test;

  localparam logic [31:0] HEAD = 32'h100;
  localparam int MEM_LAT = 2;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] IRQ = 32'h8000_0000;
  localparam logic [31:0] LST = 32'h4000_0000;
  localparam logic [31:0] FST = 32'h2000_0000;
  localparam logic [31:0] NOC = 32'h0400_0000;
  localparam logic [31:0] WRP = 32'h0200_0000;
  localparam logic [31:0] LNK = 32'h0100_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        poll_we;
  logic [31:0] poll_wdata;
  logic        mem_req, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        buf_valid, buf_ready, buf_first, buf_last, buf_nocrc;
  logic [31:0] buf_addr;
  logic [10:0] buf_len;
  logic [1:0]  buf_csum;
  logic        xfer_done, xfer_underflow, xfer_jabber, xfer_flushed;
  logic [3:0]  xfer_coll;
  logic        tx_done, suspended;

  txdesc_chain_engine uut (
    .clk(clk), .rst(rst), .chain_head(HEAD),
    .poll_we(poll_we), .poll_wdata(poll_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len),
    .buf_first(buf_first), .buf_last(buf_last), .buf_csum(buf_csum), .buf_nocrc(buf_nocrc),
    .xfer_done(xfer_done), .xfer_underflow(xfer_underflow), .xfer_jabber(xfer_jabber),
    .xfer_flushed(xfer_flushed), .xfer_coll(xfer_coll),
    .tx_done(tx_done), .suspended(suspended)
  );

  int checks = 0;
  int errors = 0;

  // memory model and logs
  logic [31:0] mem [0:255];
  logic        hw_en = 1'b0;
  logic [31:0] hw_addr = '0, hw_data = '0;
  int          pend_cnt = 0;
  logic [31:0] pend_data = '0;
  int          rd_cnt = 0, wr_cnt = 0, fcnt = 0;
  logic [31:0] fetch_log [0:63];
  logic [31:0] wl_addr [0:63];
  logic [31:0] wl_data [0:63];

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (hw_en) mem[hw_addr[9:2]] = hw_data;
    if (!rst) begin
      if (pend_cnt > 0) begin
        pend_cnt = pend_cnt - 1;
        if (pend_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = pend_data;
        end
      end
      if (mem_req) begin
        if (mem_we) begin
          mem[mem_addr[9:2]] = mem_wdata;
          wl_addr[wr_cnt[5:0]] = mem_addr;
          wl_data[wr_cnt[5:0]] = mem_wdata;
          wr_cnt = wr_cnt + 1;
        end else begin
          pend_data = mem[mem_addr[9:2]];
          rd_cnt = rd_cnt + 1;
          if (mem_addr[3:0] == 4'h0) begin
            fetch_log[fcnt[5:0]] = mem_addr;
            fcnt = fcnt + 1;
          end
        end
        pend_cnt = MEM_LAT;
      end
    end
  end

  // byte mover stub
  int          stall_cycles = 0;
  int          stall_cnt = 0;
  int          mv_cnt = 0;
  int          bcnt = 0, done_cnt = 0;
  logic [31:0] bl_addr [0:63];
  logic [10:0] bl_len [0:63];
  logic        bl_first [0:63];
  logic        bl_last [0:63];
  logic [1:0]  bl_csum [0:63];
  logic        bl_nocrc [0:63];

  always @(negedge clk) begin
    xfer_done = 1'b0;
    if (rst) begin
      buf_ready = 1'b1;
      mv_cnt = 0;
      stall_cnt = 0;
    end else begin
      if (tx_done) done_cnt = done_cnt + 1;
      if (mv_cnt > 0) begin
        mv_cnt = mv_cnt - 1;
        if (mv_cnt == 0) xfer_done = 1'b1;
      end
      if (buf_valid && stall_cnt < stall_cycles) begin
        buf_ready = 1'b0;
        stall_cnt = stall_cnt + 1;
      end else begin
        buf_ready = 1'b1;
      end
      if (buf_valid && buf_ready) begin
        bl_addr[bcnt[5:0]]  = buf_addr;
        bl_len[bcnt[5:0]]   = buf_len;
        bl_first[bcnt[5:0]] = buf_first;
        bl_last[bcnt[5:0]]  = buf_last;
        bl_csum[bcnt[5:0]]  = buf_csum;
        bl_nocrc[bcnt[5:0]] = buf_nocrc;
        bcnt = bcnt + 1;
        stall_cnt = 0;
        mv_cnt = 3;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk);
    hw_addr = a; hw_data = d; hw_en = 1'b1;
    @(negedge clk);
    #1 hw_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0,
                          input logic [31:0] w1, input logic [31:0] w2,
                          input logic [31:0] w3);
    host_wr(a, w0); host_wr(a + 4, w1); host_wr(a + 8, w2); host_wr(a + 12, w3);
  endtask

  task automatic set_stat(input logic uf, input logic jb, input logic fl,
                          input logic [3:0] cc);
    xfer_underflow = uf; xfer_jabber = jb; xfer_flushed = fl; xfer_coll = cc;
  endtask

  task automatic poll(input logic [31:0] v);
    @(negedge clk);
    poll_we = 1'b1; poll_wdata = v;
    @(negedge clk);
    poll_we = 1'b0; poll_wdata = '0;
  endtask

  task automatic poll_and_wait(input string req);
    bit ok = 0;
    poll(32'h1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      if (suspended) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(req, "walk returned to park", 32'(ok), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1", "suspended after reset", 32'(suspended), 32'd1);
    chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);
    chk("R1", "buf_valid after reset", 32'(buf_valid), 32'd0);
    chk("R1", "tx_done after reset", 32'(tx_done), 32'd0);
  endtask

  task automatic t_poll_zero();
    int r0 = rd_cnt;
    poll(32'h2);
    repeat (20) @(negedge clk);
    chk("R2", "reads after poll bit0=0", 32'(rd_cnt - r0), 32'd0);
    chk("R2", "still parked after poll bit0=0", 32'(suspended), 32'd1);
  endtask

  task automatic t_single();
    int b0 = bcnt, w0 = wr_cnt, f0 = fcnt, d0 = done_cnt, r0 = rd_cnt;
    put_desc(32'h100, OWN, IRQ | LST | FST | (32'd3 << 27) | LNK | (32'd7 << 11) | 32'd100,
             32'h4000, 32'h200);
    host_wr(32'h200, 32'h0);
    set_stat(1'b1, 1'b0, 1'b0, 4'd5);
    stall_cycles = 3;
    poll_and_wait("R2");
    stall_cycles = 0;
    chk("R1", "first fetch at chain_head", fetch_log[f0[5:0]], 32'h100);
    chk("R2", "reads for two descriptors", 32'(rd_cnt - r0), 32'd8);
    chk("R4", "one buffer request", 32'(bcnt - b0), 32'd1);
    chk("R4", "buf_addr", bl_addr[b0[5:0]], 32'h4000);
    chk("R4", "buf_len ignores size2", 32'(bl_len[b0[5:0]]), 32'd100);
    chk("R4", "buf_first", 32'(bl_first[b0[5:0]]), 32'd1);
    chk("R4", "buf_last", 32'(bl_last[b0[5:0]]), 32'd1);
    chk("R4", "buf_csum", 32'(bl_csum[b0[5:0]]), 32'd3);
    chk("R4", "buf_nocrc", 32'(bl_nocrc[b0[5:0]]), 32'd0);
    chk("R5", "one write-back", 32'(wr_cnt - w0), 32'd1);
    chk("R5", "write-back address", wl_addr[w0[5:0]], 32'h100);
    chk("R5", "write-back underflow status", wl_data[w0[5:0]], 32'h0000_802A);
    chk("R9", "done pulse with IRQ", 32'(done_cnt - d0), 32'd1);
    chk("R6", "chained next fetch", fetch_log[f0[5:0] + 6'd1], 32'h200);
    chk("R3", "parked on host-owned", 32'(suspended), 32'd1);
  endtask

  task automatic t_resume();
    int b0 = bcnt, w0 = wr_cnt, f0 = fcnt, d0 = done_cnt;
    put_desc(32'h200, 32'h0, FST | LST | NOC | LNK | 32'd60, 32'h5000, 32'h300);
    host_wr(32'h300, 32'h0);
    poll_and_wait("R3");
    chk("R3", "host-owned gave no buffer", 32'(bcnt - b0), 32'd0);
    chk("R3", "host-owned gave no write", 32'(wr_cnt - w0), 32'd0);
    chk("R3", "refetch same address", fetch_log[f0[5:0]], 32'h200);
    f0 = fcnt;
    host_wr(32'h200, OWN);
    set_stat(1'b0, 1'b1, 1'b1, 4'd0);
    poll_and_wait("R3");
    chk("R3", "resume fetches parked address", fetch_log[f0[5:0]], 32'h200);
    chk("R4", "buf_len", 32'(bl_len[b0[5:0]]), 32'd60);
    chk("R4", "buf_nocrc", 32'(bl_nocrc[b0[5:0]]), 32'd1);
    chk("R4", "buf_csum none", 32'(bl_csum[b0[5:0]]), 32'd0);
    chk("R5", "write-back jabber+flushed", wl_data[w0[5:0]], 32'h0000_E000);
    chk("R9", "no done without IRQ", 32'(done_cnt - d0), 32'd0);
  endtask

  task automatic t_multi();
    int b0 = bcnt, w0 = wr_cnt, f0 = fcnt, d0 = done_cnt;
    put_desc(32'h300, OWN, FST | (32'd1 << 27) | LNK | 32'd10, 32'h6000, 32'h340);
    put_desc(32'h340, OWN, LNK | 32'd20, 32'h6100, 32'h380);
    put_desc(32'h380, OWN, IRQ | LST | LNK | 32'd30, 32'h6200, 32'h3C0);
    host_wr(32'h3C0, 32'h0);
    set_stat(1'b0, 1'b0, 1'b0, 4'd0);
    poll_and_wait("R6");
    chk("R4", "three buffers", 32'(bcnt - b0), 32'd3);
    chk("R4", "first flags", {29'd0, bl_first[b0[5:0]], bl_first[b0[5:0]+6'd1], bl_first[b0[5:0]+6'd2]}, 32'b100);
    chk("R4", "last flags", {29'd0, bl_last[b0[5:0]], bl_last[b0[5:0]+6'd1], bl_last[b0[5:0]+6'd2]}, 32'b001);
    chk("R4", "csum on first only", {28'd0, bl_csum[b0[5:0]], bl_csum[b0[5:0]+6'd1]}, 32'b0100);
    chk("R6", "second fetch via link", fetch_log[f0[5:0]+6'd1], 32'h340);
    chk("R6", "fourth fetch via link", fetch_log[f0[5:0]+6'd3], 32'h3C0);
    chk("R5", "three clean write-backs", 32'(wr_cnt - w0), 32'd3);
    chk("R5", "clean status", wl_data[w0[5:0]+6'd2], 32'h0);
    chk("R9", "one done for frame", 32'(done_cnt - d0), 32'd1);
  endtask

  task automatic t_skip();
    int b0 = bcnt, w0 = wr_cnt;
    put_desc(32'h3C0, OWN, FST | LNK | 32'd0, 32'h7000, 32'h400);
    put_desc(32'h400, OWN, FST | LST | LNK | 32'd64, 32'h7100, 32'h440);
    host_wr(32'h440, 32'h0);
    poll_and_wait("R8");
    chk("R8", "zero-size skipped", 32'(bcnt - b0), 32'd1);
    chk("R8", "only the sized buffer", bl_addr[b0[5:0]], 32'h7100);
    chk("R8", "skipped write address", wl_addr[w0[5:0]], 32'h3C0);
    chk("R8", "skipped word0 cleared", wl_data[w0[5:0]], 32'h0);
  endtask

  task automatic t_ring();
    int b0 = bcnt, f0 = fcnt;
    put_desc(32'h440, OWN, FST | LST | 32'd8, 32'h8000, 32'h0000_DEA0);
    put_desc(32'h450, OWN, FST | LST | WRP | 32'd16, 32'h8100, 32'h0000_BEE0);
    poll_and_wait("R7");
    chk("R7", "two ring buffers", 32'(bcnt - b0), 32'd2);
    chk("R7", "stride step", fetch_log[f0[5:0]+6'd1], 32'h450);
    chk("R7", "wrap to head", fetch_log[f0[5:0]+6'd2], 32'h100);
    chk("R7", "parked at written-back head", 32'(suspended), 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    poll_we = 1'b0;
    poll_wdata = '0;
    set_stat(1'b0, 1'b0, 1'b0, 4'd0);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_poll_zero();
    t_single();
    t_resume();
    t_multi();
    t_skip();
    t_ring();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule